// File: doc/BRIEF.md
# Selectable Uplink Load-Modulation Encoder

This block turns a stream of data bits into the single control line that switches the load modulator of a passive tag. The tag uses that line to send data back to a reader. The block runs on the field clock. Each data bit lasts a fixed number of field clock cycles, 16 by default. One bit timer serves three line codes, and a 2-bit mode input picks between them: direct NRZ, Manchester and bi-phase. Each code has its own rule for polarity and transitions.

A frame opens when a start-of-frame strobe and a valid bit are both present while the block is idle. The mode is captured at that moment and held until the frame ends. Bits after the first are accepted through a valid/ready handshake. Ready is raised only in the last cycle of the current bit period. If no bit is offered at that point, the frame ends and the output returns to its idle, unmodulated level.

Top module: `uplink_encoder`

## Requirements
- R1: A bit occupies exactly 16 field clock cycles, counted from the edge that accepts it. While a frame runs, `bit_ready_o` is high only in the 16th cycle of the current bit. The next bit is taken at the edge that closes that cycle.
- R2: Mode 01 (Manchester): a data 0 is modulated (1) for the first 8 cycles and unmodulated (0) for the last 8, giving a falling mid-bit edge. A data 1 is the reverse, giving a rising mid-bit edge.
- R3: Mode 10 (bi-phase): at mid-bit (after 8 cycles), a data 0 inverts the output level and a data 1 keeps it.
- R4: Mode 10 (bi-phase): the output inverts at the start of every bit period. The first half-bit of a frame is therefore modulated (1).
- R5: Mode 00 (NRZ): for the whole bit period the output is the inverse of the data. A data 1 gives 0 (off) and a data 0 gives 1 (on).
- R6: When no valid bit is offered in the 16th cycle, the frame ends. The output is 0 from the next cycle. No transition is added to reveal a final bi-phase 1.
- R7: The mode is sampled only at frame start. Changes of `mode_i`, and further `sof_i` pulses, during a frame have no effect on the output.
- R8: During reset, and for the first two clock edges after `rst_n` rises, the output is 0 and ready is 0. Mode 11 is reserved and encodes exactly as NRZ.
- R9: While idle, a valid bit with `sof_i` low is not accepted: `bit_ready_o` and `mod_on_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Line code select: 00 NRZ, 01 Manchester, 10 bi-phase, 11 reserved (NRZ) |
| sof_i | input | 1 | Start-of-frame strobe, honoured only while idle |
| bit_valid_i | input | 1 | A data bit is offered |
| bit_data_i | input | 1 | Offered data bit |
| bit_ready_o | output | 1 | Offered bit is taken at this clock edge |
| mod_on_o | output | 1 | Load modulation on (1) or off (0) |

## Verification
The output pattern for a bit is due starting in the cycle right after the edge that accepts the bit, and it spans the next 16 cycles. The bench builds the expected sequence per cycle and pushes it into a queue at that edge. A monitor pops one entry on each falling edge. Ready is expected on the 16th falling edge after an acceptance, and the idle level on the first falling edge after the final boundary edge. The driver counts falling edges to confirm both. Reset release is allowed two edges before any stimulus, and the disturbance checks compare the output of a frame whose mode and start strobe are toggled mid-frame against the mode latched at its start.

// File: rtl/uplink_enc_pkg.sv
package uplink_enc_pkg;
  typedef enum logic [1:0] {
    MODE_NRZ  = 2'b00,
    MODE_MAN  = 2'b01,
    MODE_BIPH = 2'b10,
    MODE_RSVD = 2'b11
  } line_mode_e;
endpackage

// File: rtl/uplink_bit_timer.sv
module uplink_bit_timer #(
  parameter int CYCLES_PER_BIT = 16,
  localparam int CW   = $clog2(CYCLES_PER_BIT),
  localparam int HALF = CYCLES_PER_BIT / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          second_half_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i || !run_i) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o         = cnt_q;
  assign second_half_o = (cnt_q >= CW'(HALF));
  assign last_o        = (cnt_q == CW'(CYCLES_PER_BIT - 1));

  // R1: a new bit period always starts from count zero after the last cycle
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && last_o) |=> (cnt_q == '0));
endmodule

// File: rtl/uplink_line_coder.sv
module uplink_line_coder
  import uplink_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_mode_e mode_i,
  input  logic       busy_i,
  input  logic       load_i,
  input  logic       first_i,
  input  logic       data_i,
  input  logic       second_half_i,
  output logic       mod_o
);
  logic bit_q, bit_d;
  logic lvl_q, lvl_d;
  logic mod_raw;

  always_comb begin
    bit_d = bit_q;
    lvl_d = lvl_q;
    if (load_i) begin
      bit_d = data_i;
      lvl_d = first_i ? 1'b1 : (lvl_q ^ bit_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (load_i) begin
      bit_q <= bit_d;
      lvl_q <= lvl_d;
    end
  end

  always_comb begin
    case (mode_i)
      MODE_MAN:  mod_raw = second_half_i ? bit_q : ~bit_q;
      MODE_BIPH: mod_raw = second_half_i ? (lvl_q ^ ~bit_q) : lvl_q;
      default:   mod_raw = ~bit_q;
    endcase
  end

  assign mod_o = busy_i & mod_raw;

  // R2: Manchester mid-bit edge, direction set by the bit
  assert_man_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && mode_i == MODE_MAN && second_half_i && !$past(second_half_i))
      |-> (mod_o != $past(mod_o)) && (mod_o == bit_q));
  // R3: bi-phase mid-bit change only for a zero
  assert_biph_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && mode_i == MODE_BIPH && second_half_i && !$past(second_half_i))
      |-> ((mod_o != $past(mod_o)) == !bit_q));
  // R4: bi-phase level change at each bit start
  assert_biph_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && mode_i == MODE_BIPH && $past(load_i)) |-> (mod_o != $past(mod_o)));
  // R5: NRZ level holds through the bit
  assert_nrz_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && (mode_i == MODE_NRZ || mode_i == MODE_RSVD) && !$past(load_i))
      |-> $stable(mod_o));
endmodule

// File: rtl/uplink_encoder.sv
module uplink_encoder
  import uplink_enc_pkg::*;
#(
  parameter int CYCLES_PER_BIT = 16,
  localparam int CW = $clog2(CYCLES_PER_BIT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       sof_i,
  input  logic       bit_valid_i,
  input  logic       bit_data_i,
  output logic       bit_ready_o,
  output logic       mod_on_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          busy_q, busy_d;
  line_mode_e    mode_q, mode_d;
  logic          take, start;
  logic [CW-1:0] cnt;
  logic          second_half, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign bit_ready_o = rst_int_n & (busy_q ? last : sof_i);
  assign take        = bit_ready_o & bit_valid_i;
  assign start       = take & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        mode_d = line_mode_e'(mode_i);
      end
    end else if (last) begin
      busy_d = bit_valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      mode_q <= MODE_NRZ;
    end else begin
      busy_q <= busy_d;
      mode_q <= mode_d;
    end
  end

  uplink_bit_timer #(.CYCLES_PER_BIT(CYCLES_PER_BIT)) u_timer (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .load_i        (take),
    .run_i         (busy_q),
    .cnt_o         (cnt),
    .second_half_o (second_half),
    .last_o        (last)
  );

  uplink_line_coder u_coder (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .mode_i        (mode_q),
    .busy_i        (busy_q),
    .load_i        (take),
    .first_i       (start),
    .data_i        (bit_data_i),
    .second_half_i (second_half),
    .mod_o         (mod_on_o)
  );

  // R8: no modulation outside a frame
  assert_idle_off_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_q |-> !mod_on_o);
  // R6: frame closes one cycle after an unanswered last cycle
  assert_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && last && !bit_valid_i) |=> (!busy_q && !mod_on_o));
  // R7: latched mode never moves inside a frame
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && $past(busy_q)) |-> $stable(mode_q));
  // R1: within a frame ready coincides with the final count
  assert_ready_last_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && bit_ready_o) |-> (cnt == CW'(CYCLES_PER_BIT - 1)));
endmodule

// File: tb/uplink_encoder_bench.sv
module uplink_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 16;

  logic       clk, rst_n;
  logic [1:0] mode_i;
  logic       sof_i, bit_valid_i, bit_data_i;
  logic       bit_ready_o, mod_on_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  bit    q_val[$];
  string q_tag[$];

  uplink_encoder u_uplink_encoder (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sof_i(sof_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i),
    .bit_ready_o(bit_ready_o), .mod_on_o(mod_on_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // monitor: one expected output level per falling edge
  always @(negedge clk) begin
    if (q_val.size() > 0) begin
      bit    e;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      check_eq(t, "mod_on_o", mod_on_o, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drain();
    while (q_val.size() != 0) @(negedge clk);
  endtask

  // expected levels for one bit, from the requirements
  task automatic push_bit(input logic [1:0] m, input logic b, inout logic prev2, input string force_tag);
    logic  lvl;
    string tg;
    lvl = ~prev2;
    for (int i = 0; i < BIT_CYC; i++) begin
      bit sec, v;
      sec = (i >= BIT_CYC/2);
      case (m)
        2'b01: begin v = sec ? b : ~b; tg = "R2"; end
        2'b10: begin v = sec ? (b ? lvl : ~lvl) : lvl; tg = sec ? "R3" : "R4"; end
        2'b11: begin v = ~b; tg = "R8"; end
        default: begin v = ~b; tg = "R5"; end
      endcase
      if (force_tag != "") tg = force_tag;
      q_val.push_back(v);
      q_tag.push_back(tg);
    end
    prev2 = b ? lvl : ~lvl;
  endtask

  task automatic send_frame(input logic [1:0] m, input int n, input logic [31:0] bits,
                            input bit disturb, input string force_tag);
    logic prev2;
    int   cnt;
    prev2 = 1'b0;
    @(negedge clk);
    mode_i = m; sof_i = 1'b1; bit_valid_i = 1'b1; bit_data_i = bits[0];
    #1 check_eq("R1", "bit_ready_o at start", bit_ready_o, 1'b1);
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      push_bit(m, bits[k], prev2, force_tag);
      @(negedge clk);
      sof_i = 1'b0;
      if (k + 1 < n) bit_data_i = bits[k+1];
      else           bit_valid_i = 1'b0;
      if (disturb && k == 1) begin
        mode_i = ~m;
        sof_i  = 1'b1;
      end
      cnt = 1;
      while (!bit_ready_o) begin
        @(negedge clk);
        cnt++;
      end
      checks++;
      if (cnt != BIT_CYC) begin
        errors++;
        $display("FAIL R1 ready spacing actual=%0d expected=%0d", cnt, BIT_CYC);
      end
      @(posedge clk);
    end
    // R6: idle level due from the first cycle after the final boundary
    for (int i = 0; i < 4; i++) begin
      q_val.push_back(1'b0);
      q_tag.push_back("R6");
    end
    drain();
    sof_i = 1'b0;
    mode_i = 2'b00;
  endtask

  initial begin
    rst_n = 1'b0; mode_i = 2'b01; sof_i = 1'b1; bit_valid_i = 1'b1; bit_data_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_eq("R8", "mod_on_o in reset", mod_on_o, 1'b0);
      check_eq("R8", "bit_ready_o in reset", bit_ready_o, 1'b0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R8", "bit_ready_o during release", bit_ready_o, 1'b0);
    sof_i = 1'b0; bit_valid_i = 1'b0;
    repeat (3) @(negedge clk);

    send_frame(2'b00, 8, 32'h0000_00A6, 1'b0, "");   // R5 NRZ
    send_frame(2'b01, 8, 32'h0000_0035, 1'b0, "");   // R2 Manchester
    send_frame(2'b10, 7, 32'h0000_0066, 1'b0, "");   // R3 R4 bi-phase, ends with 1
    send_frame(2'b10, 6, 32'h0000_000B, 1'b0, "");   // R3 R4 bi-phase, ends with 0
    send_frame(2'b10, 1, 32'h0000_0001, 1'b0, "");   // R6 single bi-phase 1
    send_frame(2'b11, 5, 32'h0000_0013, 1'b0, "");   // R8 reserved mode
    send_frame(2'b01, 5, 32'h0000_0019, 1'b1, "R7"); // R7 mode and sof toggled

    // R9: valid without sof while idle
    @(negedge clk);
    bit_valid_i = 1'b1; bit_data_i = 1'b0; sof_i = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check_eq("R9", "bit_ready_o", bit_ready_o, 1'b0);
      check_eq("R9", "mod_on_o", mod_on_o, 1'b0);
    end
    bit_valid_i = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule